// File: doc/BRIEF.md
# Addressed Instruction Register Loader

This block sits inside a remote terminal on a shared command bus. A bus controller sends decoded instructions, each carrying a 3-bit mode, a 6-bit target address and a 16-bit data field. The block checks the target address against the terminal's fixed address and, when extended addressing is on, against a writable group address. It then updates one of three setup registers: bus selection and direction, transfer start address, or transfer block length.

An instruction accepted through the fixed address produces a one-cycle response word. The word confirms the new setting, or carries a status word for a status request. An instruction accepted only through the group address updates the registers but gives no response. This lets one instruction set up several terminals at once without two of them driving the bus together.

Top module: `instr_reg_loader`

## Requirements
- R1: An instruction with `instr_valid_i` high is accepted when `instr_addr_i` equals `term_addr_i`.
- R2: When `ext_addr_en_i` is high, an instruction whose address equals the programmed group address (and not the terminal address) is accepted and updates the registers.
- R3: An instruction accepted only through the group address produces no response.
- R4: When `ext_addr_en_i` is low, a group address match is ignored: no register changes and no response.
- R5: Mode code 1 loads `instr_data_i` into `bus_sel_o`.
- R6: Mode code 3 loads `instr_data_i` into `start_addr_o`.
- R7: Mode code 4 loads `instr_data_i` into `block_len_o`.
- R8: For an instruction accepted through the terminal address, `rsp_valid_o` is high for exactly the cycle after the accepting edge. `rsp_mode_o` echoes the mode, and for modes 1, 3 and 4 `rsp_word_o` equals the newly loaded register value.
- R9: Mode code 0 changes no register. Its response word is {user_status_i[7:0], ext_addr_en_i, 1'b1, prog_addr_o[5:0]}, taken at the accepting edge, with bit 15 first.
- R10: An instruction with a non-matching address, or with mode code 2, 5, 6 or 7, changes no register and produces no response.
- R11: Reset clears `bus_sel_o`, `start_addr_o`, `block_len_o`, `prog_addr_o` and `rsp_valid_o` to zero.
- R12: `prog_addr_we_i` high loads `prog_addr_i` into the programmed group address at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction strobe |
| instr_mode_i | input | 3 | Instruction mode code |
| instr_addr_i | input | 6 | Embedded target address |
| instr_data_i | input | 16 | Instruction data field |
| term_addr_i | input | 6 | Hard-wired terminal address |
| ext_addr_en_i | input | 1 | Extended (group) addressing enable |
| prog_addr_we_i | input | 1 | Group address write strobe |
| prog_addr_i | input | 6 | Group address write value |
| user_status_i | input | 8 | User status bits for mode 0 |
| bus_sel_o | output | 16 | Bus selection / direction register |
| start_addr_o | output | 16 | Start address register |
| block_len_o | output | 16 | Block length register |
| prog_addr_o | output | 6 | Programmed group address |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_mode_o | output | 3 | Mode of the instruction being answered |
| rsp_word_o | output | 16 | Response word |

## Verification
The hardest case is a group-only acceptance. The registers must change while the response stays silent, so it can only be seen when a register read-back and an empty response queue are observed together. The stimulus first writes the group address and leaves extended addressing off, to show that the match is ignored. It then enables extended addressing, repeats the instruction, and confirms that the register changed with no response. Last, it sends an instruction whose address matches both the terminal address and the group address, to show that the terminal match still answers.

// File: rtl/instr_reg_loader_pkg.sv
package instr_reg_loader_pkg;
  localparam logic [2:0] MODE_STATUS = 3'd0;
  localparam logic [2:0] MODE_BUS    = 3'd1;
  localparam logic [2:0] MODE_START  = 3'd3;
  localparam logic [2:0] MODE_LEN    = 3'd4;
  localparam int unsigned N_SETUP = 3;

  function automatic logic [2:0] setup_mode(input int unsigned idx);
    case (idx)
      0:       return MODE_BUS;
      1:       return MODE_START;
      default: return MODE_LEN;
    endcase
  endfunction

  function automatic logic mode_defined(input logic [2:0] m);
    return (m == MODE_STATUS) || (m == MODE_BUS) || (m == MODE_START) || (m == MODE_LEN);
  endfunction
endpackage

// File: rtl/irl_addr_match.sv
module irl_addr_match #(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0] instr_addr_i,
  input  logic [AW-1:0] term_addr_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic          ext_addr_en_i,
  output logic          hit_term_o,
  output logic          hit_group_o
);
  always_comb begin
    hit_term_o  = (instr_addr_i == term_addr_i);
    // group hit only counts when the terminal address did not hit
    hit_group_o = ext_addr_en_i && !hit_term_o && (instr_addr_i == prog_addr_i);
  end
endmodule

// File: rtl/irl_setup_regs.sv
module irl_setup_regs
  import instr_reg_loader_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] regs_o [N_SETUP]
);
  for (genvar g = 0; g < N_SETUP; g++) begin : g_reg
    localparam logic [2:0] CODE = setup_mode(g);
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (load_i && mode_i == CODE)  q <= data_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/irl_rsp_gen.sv
module irl_rsp_gen
  import instr_reg_loader_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          answer_i,
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] status_i,
  output logic          rsp_valid_o,
  output logic [2:0]    rsp_mode_o,
  output logic [DW-1:0] rsp_word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_mode_o  <= '0;
      rsp_word_o  <= '0;
    end else begin
      rsp_valid_o <= answer_i;
      if (answer_i) begin
        rsp_mode_o <= mode_i;
        // load modes echo the written value, which is the register's new content
        rsp_word_o <= (mode_i == MODE_STATUS) ? status_i : data_i;
      end
    end
  end
endmodule

// File: rtl/instr_reg_loader.sv
module instr_reg_loader
  import instr_reg_loader_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6,
  parameter int unsigned UW = DW - AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [2:0]    instr_mode_i,
  input  logic [AW-1:0] instr_addr_i,
  input  logic [DW-1:0] instr_data_i,
  input  logic [AW-1:0] term_addr_i,
  input  logic          ext_addr_en_i,
  input  logic          prog_addr_we_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [UW-1:0] user_status_i,
  output logic [DW-1:0] bus_sel_o,
  output logic [DW-1:0] start_addr_o,
  output logic [DW-1:0] block_len_o,
  output logic [AW-1:0] prog_addr_o,
  output logic          rsp_valid_o,
  output logic [2:0]    rsp_mode_o,
  output logic [DW-1:0] rsp_word_o
);
  logic [AW-1:0] prog_q;
  logic          hit_term, hit_group, mode_ok, accept, answer;
  logic [DW-1:0] status_word;
  logic [DW-1:0] regs [N_SETUP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             prog_q <= '0;
    else if (prog_addr_we_i) prog_q <= prog_addr_i;
  end

  irl_addr_match #(.AW(AW)) u_match (
    .instr_addr_i (instr_addr_i),
    .term_addr_i  (term_addr_i),
    .prog_addr_i  (prog_q),
    .ext_addr_en_i(ext_addr_en_i),
    .hit_term_o   (hit_term),
    .hit_group_o  (hit_group)
  );

  always_comb begin
    mode_ok     = mode_defined(instr_mode_i);
    accept      = instr_valid_i && mode_ok && (hit_term || hit_group);
    answer      = instr_valid_i && mode_ok && hit_term;
    status_word = {user_status_i, ext_addr_en_i, 1'b1, prog_q};
  end

  irl_setup_regs #(.DW(DW)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .mode_i(instr_mode_i),
    .data_i(instr_data_i),
    .regs_o(regs)
  );

  irl_rsp_gen #(.DW(DW)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .answer_i   (answer),
    .mode_i     (instr_mode_i),
    .data_i     (instr_data_i),
    .status_i   (status_word),
    .rsp_valid_o(rsp_valid_o),
    .rsp_mode_o (rsp_mode_o),
    .rsp_word_o (rsp_word_o)
  );

  assign bus_sel_o    = regs[0];
  assign start_addr_o = regs[1];
  assign block_len_o  = regs[2];
  assign prog_addr_o  = prog_q;
endmodule

// File: rtl/instr_reg_loader_chk.sv
module instr_reg_loader_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_valid_i,
  input logic [2:0]    instr_mode_i,
  input logic [AW-1:0] instr_addr_i,
  input logic [AW-1:0] term_addr_i,
  input logic          ext_addr_en_i,
  input logic [DW-1:0] bus_sel_o,
  input logic [DW-1:0] start_addr_o,
  input logic [DW-1:0] block_len_o,
  input logic [AW-1:0] prog_addr_o,
  input logic          rsp_valid_o,
  input logic [2:0]    rsp_mode_o,
  input logic [DW-1:0] rsp_word_o
);
  // R8
  rsp_needs_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(instr_valid_i) && $past(instr_addr_i) == $past(term_addr_i));
  // R10
  idle_regs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(bus_sel_o) && $stable(start_addr_o) && $stable(block_len_o));
  // R3
  group_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && ext_addr_en_i && instr_addr_i == prog_addr_o && instr_addr_i != term_addr_i)
    |=> !rsp_valid_o);
  // R10
  bad_mode_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && (instr_mode_i == 3'd2 || instr_mode_i >= 3'd5)) |=> !rsp_valid_o);
  // R8
  bus_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_mode_o == 3'd1) |-> rsp_word_o == bus_sel_o);
  // R8
  len_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_mode_o == 3'd4) |-> rsp_word_o == block_len_o);
endmodule

bind instr_reg_loader instr_reg_loader_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/instr_reg_loader_bench.sv
module instr_reg_loader_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, ext_en = 1'b0, pwe = 1'b0;
  logic [2:0]  mode = '0;
  logic [5:0]  addr = '0, term = 6'h15, paddr = '0;
  logic [15:0] data = '0;
  logic [7:0]  ustat = 8'hC3;
  logic [15:0] bus_sel, start_addr, block_len, rsp_word;
  logic [5:0]  prog_addr;
  logic        rsp_valid;
  logic [2:0]  rsp_mode;
  int total = 0, bad = 0;
  logic [18:0] exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  instr_reg_loader u_instr_reg_loader (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_mode_i(mode),
    .instr_addr_i(addr), .instr_data_i(data), .term_addr_i(term),
    .ext_addr_en_i(ext_en), .prog_addr_we_i(pwe), .prog_addr_i(paddr),
    .user_status_i(ustat), .bus_sel_o(bus_sel), .start_addr_o(start_addr),
    .block_len_o(block_len), .prog_addr_o(prog_addr), .rsp_valid_o(rsp_valid),
    .rsp_mode_o(rsp_mode), .rsp_word_o(rsp_word));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one instruction cycle, pushes expected response if any
  task automatic send(input logic [2:0] m, input logic [5:0] a, input logic [15:0] d,
                      input bit rsp, input logic [15:0] w);
    mode = m; addr = a; data = d; valid = 1'b1;
    if (rsp) exp_q.push_back({m, w});
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected response", {13'd0, rsp_mode, rsp_word}, 32'hFFFF_FFFF);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        check("R8 response", {13'd0, rsp_mode, rsp_word}, {13'd0, e});
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 bus_sel", bus_sel, 0);
    check("R11 start", start_addr, 0);
    check("R11 len", block_len, 0);
    check("R11 prog", prog_addr, 0);
    check("R11 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5 R8
    send(3'd1, term, 16'hA5A1, 1, 16'hA5A1);
    check("R5 bus_sel", bus_sel, 16'hA5A1);
    // R6
    send(3'd3, term, 16'h1234, 1, 16'h1234);
    check("R6 start", start_addr, 16'h1234);
    // R7 back-to-back with R5
    send(3'd4, term, 16'h0040, 1, 16'h0040);
    send(3'd1, term, 16'h0F0F, 1, 16'h0F0F);
    check("R7 len", block_len, 16'h0040);
    check("R5 bus_sel b2b", bus_sel, 16'h0F0F);
    // R9 status
    send(3'd0, term, 16'hFFFF, 1, {8'hC3, 1'b0, 1'b1, 6'h00});
    check("R9 regs kept", {bus_sel, start_addr}, {16'h0F0F, 16'h1234});
    // R10 non-matching address
    send(3'd3, 6'h16, 16'hDEAD, 0, 0);
    check("R10 wrong addr", start_addr, 16'h1234);
    check("R10 no rsp", rsp_valid, 0);
    // R10 undefined modes
    for (int m = 5; m < 8; m++) begin
      send(m[2:0], term, 16'hBEEF, 0, 0);
      check("R10 bad mode", {bus_sel, start_addr}, {16'h0F0F, 16'h1234});
    end
    send(3'd2, term, 16'hBEEF, 0, 0);
    check("R10 mode2", block_len, 16'h0040);
    // R12 prog addr write
    paddr = 6'h2A; pwe = 1'b1;
    @(negedge clk);
    pwe = 1'b0;
    check("R12 prog", prog_addr, 6'h2A);
    // R4 group match ignored when disabled
    send(3'd3, 6'h2A, 16'h7777, 0, 0);
    check("R4 start kept", start_addr, 16'h1234);
    check("R4 no rsp", rsp_valid, 0);
    // R2 R3 group match accepted, silent
    ext_en = 1'b1;
    @(negedge clk);
    send(3'd4, 6'h2A, 16'h0100, 0, 0);
    check("R2 len group", block_len, 16'h0100);
    check("R3 no rsp", rsp_valid, 0);
    send(3'd0, 6'h2A, 16'h0, 0, 0);
    check("R3 status silent", rsp_valid, 0);
    // R9 status with ext on
    send(3'd0, term, 16'h0, 1, {8'hC3, 1'b1, 1'b1, 6'h2A});
    // R1 terminal match still answers when group address equals it
    paddr = term; pwe = 1'b1;
    @(negedge clk);
    pwe = 1'b0;
    send(3'd3, term, 16'h4321, 1, 16'h4321);
    check("R1 both match", start_addr, 16'h4321);
    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule